// File: doc/BRIEF.md
# Full/Low-Speed USB Packet Transmitter

This block turns one packet command into the line symbols of a USB packet. A command carries a four-bit packet identifier, an 11-bit field (address and endpoint for tokens, frame number for start-of-frame), a payload length and a low-speed flag. The block sends the synchronisation pattern, the identifier byte, the field or the payload bytes, and the CRC it computes along the way. Every bit in that stream, the CRC included, is bit-stuffed. The stuffed stream is then NRZI-coded. An end-of-packet sequence closes it.

Payload bytes are pulled from the caller one at a time. The block raises `pl_take` in the clock cycle where it latches `pl_byte`, and the source then steps to its next byte. Line symbols change once per bit time, which is `BIT_CYCLES` clock cycles. The drive enable stays high from the first synchronisation symbol through the final idle symbol of the end-of-packet sequence. A new command is accepted only when no packet is in flight.

Top module: `usb_pkt_serializer`

## Requirements
- R1: Every packet begins with eight NRZ bits 0000000 then 1, which appear on the line as K J K J K J K K.
- R2: The identifier byte follows: the four type bits `cmd_pid[0]` to `cmd_pid[3]`, then their complements in the same order.
- R3: When `cmd_pid[1:0]` is 01, the 11 bits of `cmd_field` are sent least significant bit first. For tokens, bits 6:0 hold the address and bits 10:7 the endpoint.
- R4: A 5-bit CRC follows the field. It uses polynomial x^5+x^2+1, starts from all ones, and is sent inverted with its most significant bit first. Running the receive CRC over the field and the CRC leaves 01100.
- R5: When `cmd_pid[1:0]` is 11, the payload bytes go out in the order they are taken, each least significant bit first. They are followed by a 16-bit CRC with polynomial x^16+x^15+x^2+1, seeded with ones, inverted and sent most significant bit first. The receive residual is 0x800D. A zero-length payload sends 16 zero CRC bits. `pl_take` pulses once per payload byte.
- R6: When `cmd_pid[1:0]` is 10 or 00, the packet is the identifier byte alone, 16 bits before the end-of-packet sequence.
- R7: After six consecutive NRZ ones a zero is inserted. This holds within the CRC, and also when the six ones end the packet.
- R8: NRZI coding starts from the J state. An NRZ zero flips the line state and an NRZ one holds it.
- R9: The packet ends with two bit times of SE0 (both lines low) and one bit time of J, after which `usb_oe` drops.
- R10: With `cmd_ls` low, J is `usb_dp`=1, `usb_dm`=0. With `cmd_ls` high, J is `usb_dp`=0, `usb_dm`=1. K is the opposite in each case.
- R11: With `cmd_ls` high, a payload longer than `LS_MAX_LEN` (8) bytes is cut to 8 bytes.
- R12: After reset `usb_oe` is 0 and `cmd_ready` is 1. Each line symbol lasts exactly `BIT_CYCLES` clocks. `cmd_ready` stays low while a packet is being sent.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Packet command offered |
| cmd_ready | output | 1 | Transmitter idle; command taken when both are high |
| cmd_pid | input | 4 | Packet type bits |
| cmd_field | input | 11 | Address/endpoint or frame number |
| cmd_len | input | LEN_W | Payload byte count for data packets |
| cmd_ls | input | 1 | Low-speed line polarity and payload limit |
| pl_byte | input | 8 | Current payload byte from the source |
| pl_take | output | 1 | `pl_byte` latched this cycle |
| usb_dp | output | 1 | D+ drive value |
| usb_dm | output | 1 | D- drive value |
| usb_oe | output | 1 | Line drive enable |

## Verification
The bench builds the block with `BIT_CYCLES` = 3 and the default `MAX_LEN` of 1023. This keeps a full 1023-byte payload within the cycle budget. It also lets the bench sweep every address across the three token types and search all 2048 frame numbers for the few whose CRC ends in six ones. Those frames test the case where a stuffed bit falls after the last packet bit. Every payload length from 0 to 18 runs with varied contents, and a stretch of all-ones bytes exercises stuffing inside the data. The low-speed runs exercise the inverted polarity and the 8-byte limit.

// File: rtl/usb_ser_pkg.sv
package usb_ser_pkg;
  localparam logic [7:0]  SYNC_NRZ    = 8'b1000_0000;  // bit 0 goes out first
  localparam logic [4:0]  CRC5_POLY   = 5'h05;
  localparam logic [15:0] CRC16_POLY  = 16'h8005;
  localparam logic [2:0]  STUFF_AFTER = 3'd6;

  typedef enum logic [2:0] {
    FR_IDLE, FR_SYNC, FR_PID, FR_FIELD, FR_DATA, FR_CRC, FR_DONE
  } fr_state_e;

  typedef enum logic [2:0] {
    LN_IDLE, LN_RUN, LN_EOP1, LN_EOP2, LN_JEND
  } ln_state_e;

  function automatic logic [4:0] rev5(input logic [4:0] v);
    for (int i = 0; i < 5; i++) rev5[i] = v[4-i];
  endfunction

  function automatic logic [15:0] rev16(input logic [15:0] v);
    for (int i = 0; i < 16; i++) rev16[i] = v[15-i];
  endfunction
endpackage

// File: rtl/usb_ser_framer.sv
module usb_ser_framer
  import usb_ser_pkg::*;
#(
  parameter int LEN_W = 10
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start_i,
  input  logic [3:0]       pid_i,
  input  logic [10:0]      field_i,
  input  logic [LEN_W-1:0] len_i,
  input  logic             adv_i,
  input  logic             release_i,
  input  logic [7:0]       pl_byte_i,
  output logic             bit_o,
  output logic             bit_ok_o,
  output logic             done_o,
  output logic             idle_o,
  output logic             pl_take_o
);
  fr_state_e        state_q;
  logic [15:0]      sreg_q;
  logic [3:0]       cnt_q;
  logic [15:0]      crc_q;
  logic [3:0]       pid_q;
  logic [10:0]      field_q;
  logic [LEN_W-1:0] len_q, left_q;
  logic             data_q;

  logic        fb5, fb16, seg_end;
  logic [4:0]  n5;
  logic [15:0] n16, crc_nxt;

  always_comb begin
    fb5     = sreg_q[0] ^ crc_q[4];
    n5      = {crc_q[3:0], 1'b0} ^ (fb5 ? CRC5_POLY : 5'd0);
    fb16    = sreg_q[0] ^ crc_q[15];
    n16     = {crc_q[14:0], 1'b0} ^ (fb16 ? CRC16_POLY : 16'd0);
    crc_nxt = data_q ? n16 : {11'd0, n5};
    seg_end = adv_i && (cnt_q == 4'd0);
    pl_take_o = seg_end && ((state_q == FR_PID && data_q && len_q != '0) ||
                            (state_q == FR_DATA && left_q != '0));
  end

  assign bit_o    = sreg_q[0];
  assign bit_ok_o = (state_q == FR_SYNC) || (state_q == FR_PID) || (state_q == FR_FIELD) ||
                    (state_q == FR_DATA) || (state_q == FR_CRC);
  assign done_o   = (state_q == FR_DONE);
  assign idle_o   = (state_q == FR_IDLE);

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= FR_IDLE;
      sreg_q  <= '0;
      cnt_q   <= '0;
      crc_q   <= '1;
      pid_q   <= '0;
      field_q <= '0;
      len_q   <= '0;
      left_q  <= '0;
      data_q  <= 1'b0;
    end else begin
      case (state_q)
        FR_IDLE: if (start_i) begin
          pid_q   <= pid_i;
          field_q <= field_i;
          len_q   <= len_i;
          data_q  <= (pid_i[1:0] == 2'b11);
          sreg_q  <= {8'h00, SYNC_NRZ};
          cnt_q   <= 4'd7;
          crc_q   <= '1;
          state_q <= FR_SYNC;
        end
        FR_DONE: if (release_i) state_q <= FR_IDLE;
        default: if (adv_i) begin
          if (state_q == FR_FIELD || state_q == FR_DATA) crc_q <= crc_nxt;
          if (cnt_q != 4'd0) begin
            sreg_q <= {1'b0, sreg_q[15:1]};
            cnt_q  <= cnt_q - 4'd1;
          end else begin
            case (state_q)
              FR_SYNC: begin
                sreg_q  <= {8'h00, ~pid_q, pid_q};
                cnt_q   <= 4'd7;
                state_q <= FR_PID;
              end
              FR_PID: begin
                if (pid_q[1:0] == 2'b01) begin
                  sreg_q  <= {5'd0, field_q};
                  cnt_q   <= 4'd10;
                  state_q <= FR_FIELD;
                end else if (data_q && len_q != '0) begin
                  sreg_q  <= {8'h00, pl_byte_i};
                  cnt_q   <= 4'd7;
                  left_q  <= len_q - 1'b1;
                  state_q <= FR_DATA;
                end else if (data_q) begin
                  sreg_q  <= rev16(~crc_q);
                  cnt_q   <= 4'd15;
                  state_q <= FR_CRC;
                end else begin
                  state_q <= FR_DONE;
                end
              end
              FR_FIELD: begin
                sreg_q  <= {11'd0, rev5(~crc_nxt[4:0])};
                cnt_q   <= 4'd4;
                state_q <= FR_CRC;
              end
              FR_DATA: begin
                if (left_q != '0) begin
                  sreg_q <= {8'h00, pl_byte_i};
                  cnt_q  <= 4'd7;
                  left_q <= left_q - 1'b1;
                end else begin
                  sreg_q  <= rev16(~crc_nxt);
                  cnt_q   <= 4'd15;
                  state_q <= FR_CRC;
                end
              end
              FR_CRC:  state_q <= FR_DONE;
              default: state_q <= FR_IDLE;
            endcase
          end
        end
      endcase
    end
  end

  // R5
  data_entry_fetch_chk: assert property (@(posedge clk) disable iff (rst)
    (state_q == FR_DATA && $past(state_q) != FR_DATA) |-> $past(pl_take_o));

  // R6
  field_only_token_chk: assert property (@(posedge clk) disable iff (rst)
    (state_q == FR_FIELD) |-> (pid_q[1:0] == 2'b01));
endmodule

// File: rtl/usb_ser_line.sv
module usb_ser_line
  import usb_ser_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic tick_i,
  input  logic start_i,
  input  logic ls_i,
  input  logic bit_i,
  input  logic bit_ok_i,
  input  logic fr_done_i,
  output logic adv_o,
  output logic release_o,
  output logic dp_o,
  output logic dm_o,
  output logic oe_o
);
  ln_state_e st_q;
  logic      lvl_q, ls_q, dp_q, dm_q, oe_q;
  logic [2:0] ones_q;
  logic      nl;

  assign adv_o     = tick_i && (st_q == LN_RUN) && (ones_q != STUFF_AFTER) && bit_ok_i;
  assign release_o = tick_i && (st_q == LN_JEND);
  assign nl        = bit_i ? lvl_q : ~lvl_q;
  assign dp_o = dp_q;
  assign dm_o = dm_q;
  assign oe_o = oe_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q <= LN_IDLE; lvl_q <= 1'b1; ls_q <= 1'b0; ones_q <= '0;
      dp_q <= 1'b0; dm_q <= 1'b0; oe_q <= 1'b0;
    end else if (st_q == LN_IDLE && start_i) begin
      st_q <= LN_RUN; lvl_q <= 1'b1; ones_q <= '0; ls_q <= ls_i;
    end else if (tick_i) begin
      case (st_q)
        LN_RUN: begin
          if (ones_q == STUFF_AFTER) begin
            lvl_q <= ~lvl_q; ones_q <= '0;
            dp_q <= ~lvl_q ^ ls_q; dm_q <= lvl_q ^ ls_q; oe_q <= 1'b1;
          end else if (bit_ok_i) begin
            lvl_q  <= nl;
            ones_q <= bit_i ? ones_q + 3'd1 : 3'd0;
            dp_q <= nl ^ ls_q; dm_q <= ~nl ^ ls_q; oe_q <= 1'b1;
          end else if (fr_done_i) begin
            dp_q <= 1'b0; dm_q <= 1'b0; st_q <= LN_EOP1;
          end
        end
        LN_EOP1: st_q <= LN_EOP2;
        LN_EOP2: begin
          dp_q <= ~ls_q; dm_q <= ls_q; st_q <= LN_JEND;
        end
        LN_JEND: begin
          oe_q <= 1'b0; st_q <= LN_IDLE;
        end
        default: st_q <= LN_IDLE;
      endcase
    end
  end

  // run-length watch on the driven levels
  logic       tick_d_q, pdp_q;
  logic [3:0] same_q;
  always_ff @(posedge clk) begin
    if (rst) begin
      tick_d_q <= 1'b0; pdp_q <= 1'b0; same_q <= '0;
    end else begin
      tick_d_q <= tick_i;
      if (tick_d_q) begin
        if (oe_q && dp_q != dm_q) begin
          same_q <= (dp_q == pdp_q) ? same_q + 4'd1 : 4'd1;
          pdp_q  <= dp_q;
        end else begin
          same_q <= '0;
        end
      end
    end
  end

  // R7
  max_run_chk: assert property (@(posedge clk) disable iff (rst) same_q <= 4'd7);

  // R9
  eop_tail_j_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(oe_q) |-> $past(dp_q != dm_q));

  // R12
  oe_on_tick_chk: assert property (@(posedge clk) disable iff (rst)
    !$past(tick_i) |-> $stable(oe_q));
endmodule

// File: rtl/usb_pkt_serializer.sv
module usb_pkt_serializer #(
  parameter int BIT_CYCLES = 4,
  parameter int MAX_LEN    = 1023,
  parameter int LS_MAX_LEN = 8,
  localparam int LEN_W     = $clog2(MAX_LEN + 1),
  localparam int DIV_W     = (BIT_CYCLES > 1) ? $clog2(BIT_CYCLES) : 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cmd_valid,
  output logic             cmd_ready,
  input  logic [3:0]       cmd_pid,
  input  logic [10:0]      cmd_field,
  input  logic [LEN_W-1:0] cmd_len,
  input  logic             cmd_ls,
  input  logic [7:0]       pl_byte,
  output logic             pl_take,
  output logic             usb_dp,
  output logic             usb_dm,
  output logic             usb_oe
);
  logic [DIV_W-1:0] div_q;
  logic             tick, start, fr_idle;
  logic [LEN_W-1:0] len_eff;
  logic             f_bit, f_ok, f_done, adv, rel;

  assign tick = (div_q == DIV_W'(BIT_CYCLES - 1));

  always_ff @(posedge clk) begin
    if (rst || tick) div_q <= '0;
    else             div_q <= div_q + 1'b1;
  end

  assign cmd_ready = fr_idle;
  assign start     = cmd_valid && cmd_ready;
  assign len_eff   = (cmd_ls && cmd_len > LEN_W'(LS_MAX_LEN)) ? LEN_W'(LS_MAX_LEN) : cmd_len;

  usb_ser_framer #(.LEN_W(LEN_W)) u_framer (
    .clk(clk), .rst(rst), .start_i(start), .pid_i(cmd_pid), .field_i(cmd_field),
    .len_i(len_eff), .adv_i(adv), .release_i(rel), .pl_byte_i(pl_byte),
    .bit_o(f_bit), .bit_ok_o(f_ok), .done_o(f_done), .idle_o(fr_idle), .pl_take_o(pl_take)
  );

  usb_ser_line u_line (
    .clk(clk), .rst(rst), .tick_i(tick), .start_i(start), .ls_i(cmd_ls),
    .bit_i(f_bit), .bit_ok_i(f_ok), .fr_done_i(f_done), .adv_o(adv), .release_o(rel),
    .dp_o(usb_dp), .dm_o(usb_dm), .oe_o(usb_oe)
  );

  // R12
  busy_not_ready_chk: assert property (@(posedge clk) disable iff (rst)
    usb_oe |-> !cmd_ready);
endmodule

// File: tb/usb_pkt_serializer_tb.sv
`timescale 1ns/100ps
module usb_pkt_serializer_tb;
  localparam int BC = 3;
  localparam int LW = 10;

  logic clk = 0, rst = 1;
  logic cmd_valid = 0, cmd_ls = 0, pclr = 0;
  logic [3:0] cmd_pid = 0;
  logic [10:0] cmd_field = 0;
  logic [LW-1:0] cmd_len = 0;
  logic [7:0] pl_byte;
  logic cmd_ready, pl_take, usb_dp, usb_dm, usb_oe;

  always #2.5 clk = ~clk;

  usb_pkt_serializer #(.BIT_CYCLES(BC)) u_dut (
    .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_pid(cmd_pid), .cmd_field(cmd_field), .cmd_len(cmd_len), .cmd_ls(cmd_ls),
    .pl_byte(pl_byte), .pl_take(pl_take), .usb_dp(usb_dp), .usb_dm(usb_dm), .usb_oe(usb_oe)
  );

  logic [7:0] pay [0:1023];
  int pidx;
  assign pl_byte = pay[pidx[9:0]];
  always @(posedge clk) if (pclr) pidx <= 0; else if (pl_take) pidx <= pidx + 1;

  bit nrz [0:9999];
  int nn;
  logic [1:0] es [0:11999];
  logic [1:0] gs [0:11999];
  int en, gn, total, bad, cyc;
  bit tail_stuff, saw_tail;

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic logic [1:0] sym(input bit lvl, input bit ls);
    return {lvl ^ ls, ~lvl ^ ls};
  endfunction

  task automatic push(input bit b);
    nrz[nn] = b; nn++;
  endtask

  task automatic build(input logic [3:0] pid, input logic [10:0] fld, input int len, input bit ls);
    logic [4:0] c5; logic [15:0] c16; bit fb, lvl; int ones;
    nn = 0;
    for (int i = 0; i < 7; i++) push(1'b0);
    push(1'b1);
    for (int i = 0; i < 4; i++) push(pid[i]);
    for (int i = 0; i < 4; i++) push(~pid[i]);
    if (pid[1:0] == 2'b01) begin
      c5 = 5'h1F;
      for (int i = 0; i < 11; i++) begin
        push(fld[i]); fb = fld[i] ^ c5[4];
        c5 = {c5[3:0], 1'b0} ^ (fb ? 5'h05 : 5'h00);
      end
      c5 = ~c5;
      for (int i = 4; i >= 0; i--) push(c5[i]);
    end else if (pid[1:0] == 2'b11) begin
      c16 = 16'hFFFF;
      for (int k = 0; k < len; k++)
        for (int j = 0; j < 8; j++) begin
          push(pay[k][j]); fb = pay[k][j] ^ c16[15];
          c16 = {c16[14:0], 1'b0} ^ (fb ? 16'h8005 : 16'h0000);
        end
      c16 = ~c16;
      for (int i = 15; i >= 0; i--) push(c16[i]);
    end
    en = 0; lvl = 1; ones = 0; tail_stuff = 0;
    for (int i = 0; i < nn; i++) begin
      if (nrz[i]) ones++; else begin lvl = ~lvl; ones = 0; end
      es[en] = sym(lvl, ls); en++;
      if (ones == 6) begin
        lvl = ~lvl; ones = 0; es[en] = sym(lvl, ls); en++;
        if (i == nn - 1) tail_stuff = 1;
      end
    end
    es[en] = 2'b00; es[en+1] = 2'b00; es[en+2] = sym(1'b1, ls); en += 3;
  endtask

  task automatic run_pkt(input logic [3:0] pid, input logic [10:0] fld, input int len,
                         input bit ls, input string req);
    int eff, w, mis, ones, rn; bit rdy_ok, lvl, prev, b, fb;
    logic [4:0] c5; logic [15:0] c16;
    bit rb [0:9999];
    eff = (ls && len > 8) ? 8 : len;
    build(pid, fld, (pid[1:0] == 2'b11) ? eff : 0, ls);
    @(negedge clk);
    cmd_pid = pid; cmd_field = fld; cmd_len = LW'(len); cmd_ls = ls; cmd_valid = 1; pclr = 1;
    @(negedge clk);
    cmd_valid = 0; pclr = 0;
    w = 0;
    while (!usb_oe && w < 10 * BC) begin @(negedge clk); w++; end
    gn = 0; rdy_ok = 1;
    while (usb_oe && gn < 12000) begin
      gs[gn] = {usb_dp, usb_dm}; gn++;
      if (cmd_ready) rdy_ok = 0;
      repeat (BC) @(negedge clk);
    end
    chk(rdy_ok, "R12", "cmd_ready low while sending", rdy_ok, 1);
    mis = -1;
    for (int i = 0; i < en && i < gn; i++) if (mis < 0 && gs[i] !== es[i]) mis = i;
    chk(gn == en, req, "symbol count", gn, en);
    chk(mis < 0, req, "first mismatching symbol index", mis, -1);
    chk(gn >= 8 && gs[0] == sym(0, ls) && gs[1] == sym(1, ls) && gs[6] == sym(0, ls) && gs[7] == sym(0, ls),
        "R1", "sync pattern", (gn >= 8) ? int'(gs[7]) : -1, int'(sym(0, ls)));
    chk(gn >= 3 && gs[gn-1] == sym(1, ls) && gs[gn-2] == 2'b00 && gs[gn-3] == 2'b00,
        "R9", "end-of-packet tail", (gn >= 1) ? int'(gs[gn-1]) : -1, int'(sym(1, ls)));
    // decode the captured line: NRZI back to NRZ, drop stuffed bits
    rn = 0; prev = 1; ones = 0;
    for (int i = 0; i < gn && gs[i] != 2'b00; i++) begin
      lvl = gs[i][1] ^ ls; b = (lvl == prev); prev = lvl;
      if (ones == 6) ones = 0;
      else begin rb[rn] = b; rn++; ones = b ? ones + 1 : 0; end
    end
    if (pid[1:0] == 2'b01) begin
      c5 = 5'h1F;
      for (int i = 16; i < rn; i++) begin fb = rb[i] ^ c5[4]; c5 = {c5[3:0], 1'b0} ^ (fb ? 5'h05 : 5'h00); end
      chk(c5 == 5'b01100 && rn == 32, "R4", "token CRC residual", c5, 12);
    end else if (pid[1:0] == 2'b11) begin
      c16 = 16'hFFFF;
      for (int i = 16; i < rn; i++) begin fb = rb[i] ^ c16[15]; c16 = {c16[14:0], 1'b0} ^ (fb ? 16'h8005 : 16'h0000); end
      chk(c16 == 16'h800D, "R5", "data CRC residual", c16, 32781);
      chk(pidx == eff, ls ? "R11" : "R5", "bytes taken", pidx, eff);
    end else begin
      chk(rn == 16, "R6", "identifier-only length", rn, 16);
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 190000) begin
      total++; bad++;
      $display("FAIL R12 watchdog expired: actual=%0d expected=%0d", cyc, 190000);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [3:0] hs [0:3];
    logic [3:0] tk [0:2];
    hs[0] = 4'b0010; hs[1] = 4'b1010; hs[2] = 4'b1110; hs[3] = 4'b1100;
    tk[0] = 4'b0001; tk[1] = 4'b1001; tk[2] = 4'b1101;
    total = 0; bad = 0; cyc = 0; saw_tail = 0;
    for (int i = 0; i < 1024; i++) pay[i] = 8'h00;
    repeat (4) @(negedge clk);
    rst = 0;
    @(negedge clk);
    chk(usb_oe == 0, "R12", "oe after reset", usb_oe, 0);
    chk(cmd_ready == 1, "R12", "ready after reset", cmd_ready, 1);

    // identifier-only packets, both speeds (R2 R6 R10)
    for (int s = 0; s < 2; s++)
      for (int i = 0; i < 4; i++) run_pkt(hs[i], 11'h7FF, 5, s[0], "R2");

    // every address, rotating token types and endpoints (R3 R8)
    for (int a = 0; a < 128; a++)
      run_pkt(tk[a % 3], {4'(a % 16), 7'(a)}, 0, (a % 16) == 5, "R3");

    // frame numbers: a spread plus all with a stuffed bit after the CRC (R7)
    for (int f = 0; f < 2048; f++) begin
      build(4'b0101, 11'(f), 0, 0);
      if (tail_stuff || (f % 128) == 0) begin
        if (tail_stuff) saw_tail = 1;
        run_pkt(4'b0101, 11'(f), 0, 0, tail_stuff ? "R7" : "R4");
      end
    end
    chk(saw_tail, "R7", "stuff after last bit exercised", saw_tail, 1);

    // payload lengths 0..18 (R5 R8)
    for (int l = 0; l <= 18; l++) begin
      for (int k = 0; k < l; k++) pay[k] = 8'((k * 37 + l * 11) ^ (l << 3));
      run_pkt((l % 2) ? 4'b1011 : 4'b0011, 11'd0, l, 0, "R5");
    end
    // long runs of ones inside the payload (R7)
    for (int k = 0; k < 20; k++) pay[k] = 8'hFF;
    run_pkt(4'b0011, 11'd0, 20, 0, "R7");
    // full-size payload (R5)
    for (int k = 0; k < 1023; k++) pay[k] = 8'(k ^ (k >> 3));
    run_pkt(4'b1011, 11'd0, 1023, 0, "R5");
    // low-speed polarity and payload limit (R10 R11)
    for (int k = 0; k < 16; k++) pay[k] = 8'(8'hA5 + k * 3);
    run_pkt(4'b0011, 11'd0, 12, 1, "R11");
    run_pkt(4'b1011, 11'd0, 5, 1, "R10");
    run_pkt(4'b0011, 11'd0, 0, 1, "R10");
    run_pkt(4'b0011, 11'd0, 8, 1, "R11");

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule